// File: doc/BRIEF.md
# Receive Loopback and Inversion Selector

This block sits in front of the per-channel receive engine of a time-slot multiplexed serial controller. Each active time slot hands it one byte tagged with a channel number. For that byte the block picks a source. Normally the byte comes from the trunk input. If the slot belongs to the one receive channel configured for loopback, the byte is instead taken from a small internal buffer. That buffer is filled by the one transmit channel configured for loopback.

After the source is chosen, the block can invert every bit of the byte, under a per-channel inversion mask. Inversion applies to flags, aborts and checksum bits alike, since the whole byte is flipped. The result leaves on a registered output one clock later, tagged with its channel.

Configuration arrives as single-cycle writes to four settings: the transmit loop register, the receive loop register, the inversion mask and the bonded-channel mask. A loop request aimed at a bonded (multi-slot) channel is refused. Reset clears both loops, empties the buffer and puts every channel in inversion mode.

Top module: `rx_loop_sel`

## Requirements
- R1: A slot byte presented with `slotValid` high in cycle N, on a channel that is not the active receive loop channel, appears in cycle N+1 on `outByte` with `outValid` high and `outChan` equal to its channel. Its value is `rxByte`, XORed with all ones if that channel's inversion bit is set. A cycle with `slotValid` low gives `outValid` low in the next cycle.
- R2: The transmit loop (`cfgSel`=0) and the receive loop (`cfgSel`=1) are written independently. Each write uses `cfgData[4:0]` as the channel and `cfgData[5]` as the enable. The two channel numbers may differ. A channel that is only the transmit loop channel keeps receiving from the trunk.
- R3: A byte on `txByte` with `txValid` high and `txChan` equal to the enabled transmit loop channel is appended to the loop buffer. A slot of the enabled receive loop channel takes the oldest buffered byte in place of `rxByte`, so bytes come out in first-in first-out order.
- R4: A loop write with enable set, whose channel has its bit set in the bonded-channel mask (`cfgSel`=3, bit i for channel i), changes nothing: the loop settings and the buffer contents stay as they were.
- R5: After reset, both loops are disabled, the buffer is empty, the bonded-channel mask is zero, every inversion bit is set, and `outValid` and `loopOvf` are low.
- R6: The inversion mask (`cfgSel`=2, bit i for channel i) inverts all bits of the selected byte. Inversion is applied after source selection, so looped bytes are inverted too.
- R7: A configuration write in cycle N governs slots and transmit bytes presented from cycle N+1 onward. A slot presented in cycle N itself still uses the old settings.
- R8: The buffer holds 4 bytes. A push into a full buffer in a cycle with no pop drops that byte and raises `loopOvf` for exactly one cycle, in the next cycle.
- R9: A receive loop slot that finds the buffer empty yields an all-ones byte before inversion. Every accepted write to either loop register empties the buffer.
- R10: Only one receive and one transmit loop channel exist at a time. Writing a new receive loop channel returns the previous one to the trunk source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Setting selector: 0 tx loop, 1 rx loop, 2 inversion mask, 3 bonded mask |
| cfgData | input | 32 | Write data (loop channel and enable, or a per-channel mask) |
| txValid | input | 1 | Transmit byte strobe |
| txChan | input | 5 | Channel of the transmit byte |
| txByte | input | 8 | Transmit byte |
| slotValid | input | 1 | Receive slot strobe |
| slotChan | input | 5 | Channel of the receive slot |
| rxByte | input | 8 | Trunk byte for the slot |
| outValid | output | 1 | Output byte strobe |
| outChan | output | 5 | Channel of the output byte |
| outByte | output | 8 | Selected and optionally inverted byte |
| loopOvf | output | 1 | One-cycle pulse: a loop byte was dropped |

## Verification
Every output is one register away from the inputs. A slot byte, its channel, its validity and any overflow pulse are therefore all due exactly one clock after the cycle that presented them. Configuration writes act on the very next cycle.

The bench drives inputs at the falling edge. It predicts the outputs from a reference model of the settings and of the buffer queue, taken before that cycle's updates. It then steps one rising edge and compares at the following falling edge. Same-cycle races are covered by directed cases: a write together with a slot, a push together with a pop on an empty buffer, and a flush together with a push.

// File: rtl/rls_pkg.sv
`timescale 1ns/1ps
package rls_pkg;

  typedef enum logic [1:0] {
    CFG_TXLOOP = 2'd0,
    CFG_RXLOOP = 2'd1,
    CFG_INVERT = 2'd2,
    CFG_HYPER  = 2'd3
  } rlsCfgSel_t;

  // strobes from control to datapath, valid in the same cycle
  typedef struct packed {
    logic push;    // append txByte to the loop buffer
    logic pop;     // this slot takes its byte from the loop buffer
    logic flush;   // empty the loop buffer
    logic invert;  // invert the selected byte
  } rlsStrb_t;

endpackage

// File: rtl/rls_loop_fifo.sv
`timescale 1ns/1ps
module rls_loop_fifo #(
  parameter int BW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic [BW-1:0] pushByte,
  input  logic          pop,
  input  logic          flush,
  output logic [BW-1:0] headByte,
  output logic          empty,
  output logic          ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [BW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          full, doPush, doPop;

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign doPop    = pop && !empty;
  assign doPush   = push && (!full || doPop);
  assign headByte = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!flush && doPush) mem[wrPtr] <= pushByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
      ovf   <= push && full && !doPop;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R8
  AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    push && !pop && full && !flush |=> ovf); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> empty && !ovf); // R9

endmodule

// File: rtl/rls_ctrl.sv
`timescale 1ns/1ps
module rls_ctrl
  import rls_pkg::*;
#(
  parameter int NCHAN = 32,
  parameter int CHW   = $clog2(NCHAN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgSel,
  input  logic [NCHAN-1:0] cfgData,
  input  logic             txValid,
  input  logic [CHW-1:0]   txChan,
  input  logic             slotValid,
  input  logic [CHW-1:0]   slotChan,
  output rlsStrb_t         strb
);
  rlsCfgSel_t       sel;
  logic             txLoopEn, rxLoopEn;
  logic [CHW-1:0]   txLoopCh, rxLoopCh;
  logic [NCHAN-1:0] invMask, hyperMask;
  logic             reqEn, reqOk, txAcc, rxAcc;
  logic [CHW-1:0]   reqCh;

  assign sel   = rlsCfgSel_t'(cfgSel);
  assign reqEn = cfgData[CHW];
  assign reqCh = cfgData[CHW-1:0];
  assign reqOk = !(reqEn && hyperMask[reqCh]);
  assign txAcc = cfgWe && (sel == CFG_TXLOOP) && reqOk;
  assign rxAcc = cfgWe && (sel == CFG_RXLOOP) && reqOk;

  always_comb begin
    strb.push   = txValid && txLoopEn && (txChan == txLoopCh);
    strb.pop    = slotValid && rxLoopEn && (slotChan == rxLoopCh);
    strb.flush  = txAcc || rxAcc;
    strb.invert = invMask[slotChan];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txLoopEn  <= 1'b0;
      txLoopCh  <= '0;
      rxLoopEn  <= 1'b0;
      rxLoopCh  <= '0;
      invMask   <= '1;
      hyperMask <= '0;
    end else begin
      if (txAcc) begin
        txLoopEn <= reqEn;
        txLoopCh <= reqCh;
      end
      if (rxAcc) begin
        rxLoopEn <= reqEn;
        rxLoopCh <= reqCh;
      end
      if (cfgWe && sel == CFG_INVERT) invMask   <= cfgData;
      if (cfgWe && sel == CFG_HYPER)  hyperMask <= cfgData;
    end
  end

  AST_RX_HYPER_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe && sel == CFG_RXLOOP && reqEn && hyperMask[reqCh]
      |=> $stable(rxLoopEn) && $stable(rxLoopCh)); // R4
  AST_TX_HYPER_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe && sel == CFG_TXLOOP && reqEn && hyperMask[reqCh]
      |=> $stable(txLoopEn) && $stable(txLoopCh)); // R4

endmodule

// File: rtl/rls_dpath.sv
`timescale 1ns/1ps
module rls_dpath
  import rls_pkg::*;
#(
  parameter int NCHAN = 32,
  parameter int CHW   = $clog2(NCHAN),
  parameter int BW    = 8,
  parameter int DEPTH = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  rlsStrb_t       strb,
  input  logic           slotValid,
  input  logic [CHW-1:0] slotChan,
  input  logic [BW-1:0]  rxByte,
  input  logic [BW-1:0]  txByte,
  output logic           outValid,
  output logic [CHW-1:0] outChan,
  output logic [BW-1:0]  outByte,
  output logic           loopOvf
);
  localparam logic [BW-1:0] IDLE = '1;

  logic [BW-1:0] headByte, srcByte;
  logic          fifoEmpty;

  rls_loop_fifo #(.BW(BW), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strb.push),
    .pushByte (txByte),
    .pop      (strb.pop),
    .flush    (strb.flush),
    .headByte (headByte),
    .empty    (fifoEmpty),
    .ovf      (loopOvf)
  );

  always_comb begin
    if (strb.pop) srcByte = fifoEmpty ? IDLE : headByte;
    else          srcByte = rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outChan  <= '0;
      outByte  <= '0;
    end else begin
      outValid <= slotValid;
      outChan  <= slotChan;
      outByte  <= srcByte ^ {BW{strb.invert}};
    end
  end

  AST_OUT_FOLLOWS_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    slotValid |=> outValid && outChan == $past(slotChan)); // R1
  AST_OUT_IDLE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    !slotValid |=> !outValid); // R1

endmodule

// File: rtl/rx_loop_sel.sv
`timescale 1ns/1ps
module rx_loop_sel
  import rls_pkg::*;
#(
  parameter int NCHAN = 32,
  parameter int BW    = 8,
  parameter int DEPTH = 4,
  localparam int CHW  = $clog2(NCHAN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgSel,
  input  logic [NCHAN-1:0] cfgData,
  input  logic             txValid,
  input  logic [CHW-1:0]   txChan,
  input  logic [BW-1:0]    txByte,
  input  logic             slotValid,
  input  logic [CHW-1:0]   slotChan,
  input  logic [BW-1:0]    rxByte,
  output logic             outValid,
  output logic [CHW-1:0]   outChan,
  output logic [BW-1:0]    outByte,
  output logic             loopOvf
);
  rlsStrb_t strb;

  rls_ctrl #(.NCHAN(NCHAN), .CHW(CHW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgSel    (cfgSel),
    .cfgData   (cfgData),
    .txValid   (txValid),
    .txChan    (txChan),
    .slotValid (slotValid),
    .slotChan  (slotChan),
    .strb      (strb)
  );

  rls_dpath #(.NCHAN(NCHAN), .CHW(CHW), .BW(BW), .DEPTH(DEPTH)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .slotValid (slotValid),
    .slotChan  (slotChan),
    .rxByte    (rxByte),
    .txByte    (txByte),
    .outValid  (outValid),
    .outChan   (outChan),
    .outByte   (outByte),
    .loopOvf   (loopOvf)
  );

endmodule

// File: tb/rx_loop_sel_tb.sv
`timescale 1ns/1ps
module rx_loop_sel_tb;
  localparam int NCHAN = 32;
  localparam int CHW   = 5;
  localparam int BW    = 8;
  localparam int DEPTH = 4;

  logic             clk = 1'b0;
  logic             rstN;
  logic             cfgWe;
  logic [1:0]       cfgSel;
  logic [NCHAN-1:0] cfgData;
  logic             txValid;
  logic [CHW-1:0]   txChan;
  logic [BW-1:0]    txByte;
  logic             slotValid;
  logic [CHW-1:0]   slotChan;
  logic [BW-1:0]    rxByte;
  logic             outValid;
  logic [CHW-1:0]   outChan;
  logic [BW-1:0]    outByte;
  logic             loopOvf;

  always #10 clk = ~clk;

  rx_loop_sel u_dut (.*);

  int  errors = 0;
  int  checks = 0;
  bit  done   = 1'b0;

  // reference model
  logic             mTxEn, mRxEn;
  logic [CHW-1:0]   mTxCh, mRxCh;
  logic [NCHAN-1:0] mInv, mHyper;
  logic [BW-1:0]    q[$];
  string            dirTag = "";

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clearIn();
    cfgWe = 0; cfgSel = 0; cfgData = 0;
    txValid = 0; txChan = 0; txByte = 0;
    slotValid = 0; slotChan = 0; rxByte = 0;
  endtask

  function automatic void modelReset();
    mTxEn = 0; mRxEn = 0; mTxCh = 0; mRxCh = 0;
    mInv = '1; mHyper = '0;
    q.delete();
  endfunction

  // inputs are already applied; predict, clock once, compare
  task automatic runCycle();
    logic          push, pop, ok, flush, expOvf, wasFull, doPop;
    logic [BW-1:0] src, expByte;
    logic          expValid;
    logic [CHW-1:0] expChan, reqCh;
    string         tag;
    push = txValid && mTxEn && (txChan == mTxCh);
    pop  = slotValid && mRxEn && (slotChan == mRxCh);
    src  = pop ? ((q.size() > 0) ? q[0] : 8'hFF) : rxByte;
    expByte  = src ^ {BW{mInv[slotChan]}};
    expValid = slotValid;
    expChan  = slotChan;
    tag = pop ? ((q.size() > 0) ? "R3" : "R9") : "R1";
    if (dirTag != "") tag = dirTag;
    reqCh = cfgData[CHW-1:0];
    ok    = !(cfgData[CHW] && mHyper[reqCh]);
    flush = cfgWe && (cfgSel == 2'd0 || cfgSel == 2'd1) && ok;
    expOvf = 0;
    if (flush) q.delete();
    else begin
      wasFull = (q.size() == DEPTH);
      doPop   = pop && (q.size() > 0);
      if (doPop) void'(q.pop_front());
      if (push) begin
        if (!wasFull || doPop) q.push_back(txByte);
        else expOvf = 1;
      end
    end
    if (cfgWe) begin
      case (cfgSel)
        2'd0: if (ok) begin mTxEn = cfgData[CHW]; mTxCh = reqCh; end
        2'd1: if (ok) begin mRxEn = cfgData[CHW]; mRxCh = reqCh; end
        2'd2: mInv = cfgData;
        default: mHyper = cfgData;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "outValid", int'(outValid), int'(expValid));
    if (expValid) begin
      chk(tag, "outChan", int'(outChan), int'(expChan));
      chk(tag, "outByte", int'(outByte), int'(expByte));
    end
    chk("R8", "loopOvf", int'(loopOvf), int'(expOvf));
    clearIn();
  endtask

  task automatic cfgWrite(input logic [1:0] s, input logic [31:0] d);
    cfgWe = 1; cfgSel = s; cfgData = d; runCycle();
  endtask
  task automatic slot(input int ch, input logic [7:0] b);
    slotValid = 1; slotChan = CHW'(ch); rxByte = b; runCycle();
  endtask
  task automatic txPut(input int ch, input logic [7:0] b);
    txValid = 1; txChan = CHW'(ch); txByte = b; runCycle();
  endtask
  function automatic logic [31:0] loopWord(input bit en, input int ch);
    return (32'(en) << CHW) | 32'(ch);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    clearIn();
    rstN = 0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R5", "outValid", int'(outValid), 0);
    chk("R5", "loopOvf", int'(loopOvf), 0);

    // R5: inversion on for every channel after reset
    dirTag = "R5"; slot(3, 8'h5A); slot(31, 8'h00);

    // R7: write in the same cycle as a slot uses old mask
    dirTag = "R7";
    cfgWe = 1; cfgSel = 2'd2; cfgData = 32'h0; slotValid = 1; slotChan = 3; rxByte = 8'h3C;
    runCycle();
    slot(3, 8'h3C);

    // R2: independent tx/rx loop channels
    dirTag = "R2";
    cfgWrite(2'd0, loopWord(1, 4));
    cfgWrite(2'd1, loopWord(1, 9));
    txPut(4, 8'h11);
    txPut(4, 8'h22);
    slot(4, 8'h44);
    dirTag = "R3"; slot(9, 8'h77); slot(9, 8'h77);
    dirTag = "R9"; slot(9, 8'h77);
    // push and pop together on empty buffer: idle out, byte kept
    txValid = 1; txChan = 4; txByte = 8'h99; slotValid = 1; slotChan = 9; rxByte = 8'h01;
    runCycle();
    dirTag = "R3"; slot(9, 8'h01);

    // R6: inversion after selection
    dirTag = "R6";
    cfgWrite(2'd2, 32'h1 << 9);
    txPut(4, 8'h0F);
    slot(9, 8'h00);
    cfgWrite(2'd2, 32'h0);

    // R8: overflow on fifth push
    dirTag = "R8";
    for (int i = 0; i < 6; i++) txPut(4, 8'(8'hA0 + i));
    for (int i = 0; i < 5; i++) slot(9, 8'h00);

    // R9: accepted loop write flushes, also when it races a push
    dirTag = "R9";
    txPut(4, 8'h31); txPut(4, 8'h32);
    cfgWe = 1; cfgSel = 2'd1; cfgData = loopWord(1, 9); txValid = 1; txChan = 4; txByte = 8'h33;
    runCycle();
    slot(9, 8'h00);

    // R4: loop request on a bonded channel is ignored
    dirTag = "R4";
    cfgWrite(2'd3, 32'h1 << 12);
    txPut(4, 8'hAB);
    cfgWrite(2'd1, loopWord(1, 12));
    cfgWrite(2'd0, loopWord(1, 12));
    slot(12, 8'h5C);
    slot(9, 8'h00);
    txPut(4, 8'hCD);
    slot(9, 8'h00);

    // R10: new receive loop channel returns the old one to trunk
    dirTag = "R10";
    cfgWrite(2'd1, loopWord(1, 10));
    slot(9, 8'h66);
    txPut(4, 8'hEE);
    slot(10, 8'h00);
    dirTag = "";

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 99) < 3) begin
        cfgWe  = 1;
        cfgSel = 2'($urandom_range(0, 3));
        if (cfgSel < 2) cfgData = loopWord(1'($urandom_range(0, 3) != 0), $urandom_range(0, 7));
        else if (cfgSel == 2) cfgData = $urandom;
        else cfgData = $urandom & $urandom & $urandom & 32'hFF;
      end
      txValid   = 1'($urandom_range(0, 1));
      txChan    = CHW'($urandom_range(0, 7));
      txByte    = 8'($urandom);
      slotValid = ($urandom_range(0, 3) != 0);
      slotChan  = CHW'($urandom_range(0, 7));
      rxByte    = 8'($urandom);
      runCycle();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule